// File: doc/BRIEF.md
# Parallel Truncated-FIR Equalizer

This block equalizes a sample stream that arrives many samples at a time. Each clock that carries an input block, it accepts `LANES` consecutive samples. Later, it returns `LANES` filtered samples. The filter is a moving-average structure with no feedback. Its taps are the leading terms of a low-order recursive equalizer's impulse response. The response is cut off where the remaining tail falls below one output quantization step. Because no output depends on an earlier output, every lane is computed independently and the datapath is freely pipelined.

The block keeps the last `TAPS-1` samples of earlier blocks. Every lane can therefore form a complete convolution even when its oldest taps reach back across a block boundary. A slower controller refits the taps as channel conditions drift and loads them one word at a time into a staging bank. A commit strobe then promotes the whole staged set to the working set at the next accepted input block. Because of this, no output block ever mixes taps from two sets.

Top module: `feq_top`

## Requirements
- R1: Lane k of the output for input block n equals round-and-saturate of the sum over i of h[i]·x[n·LANES+k−i], where h[i] is the working tap written at coefficient address i. Samples older than the current block come from earlier accepted blocks.
- R2: Reset clears the sample history, so the first block after reset is filtered as if all earlier input samples were zero.
- R3: The full-precision sum is scaled by 2^-FRAC (FRAC=15, taps in Q1.15) with rounding to nearest, ties toward positive: the result is floor((sum + 2^(FRAC-1)) / 2^FRAC).
- R4: A scaled result above 32767 gives 32767, and one below −32768 gives −32768.
- R5: `outValid` is `inValid` delayed by exactly LAT clocks (default 4), with one output block for each accepted input block. While `outValid` is low, `outData` holds its previous value.
- R6: Coefficient writes while no commit is outstanding have no effect on output blocks computed from input blocks accepted before the next commit.
- R7: After `coefCommit` is asserted in a cycle with `inValid` low, the next accepted block and all later ones use the staged set. A commit in the same cycle as an accepted block applies to that block.
- R8: During and right after reset, `outValid` is 0, `outData` is 0 and the working taps are all zero, so blocks sent before any commit produce zero outputs.
- R9: Cycles with `inValid` low neither shift the history nor produce output. The next block continues the convolution from the last accepted block.
- R10: Lane k occupies bits [16k+15:16k] of `inData` and `outData`. Lane 0 carries the oldest sample of the block and lane LANES−1 the newest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input block present this cycle |
| inData | input | LANES*16 | Signed input samples, lane k at bits [16k+15:16k] |
| coefWrEn | input | 1 | Write one staged tap |
| coefWrAddr | input | clog2(TAPS) | Tap index to write |
| coefWrData | input | 16 | Signed Q1.15 tap value |
| coefCommit | input | 1 | Promote staged taps at the next accepted block |
| outValid | output | 1 | Output block present |
| outData | output | LANES*16 | Signed filtered samples, lane k at bits [16k+15:16k] |

## Verification
An impulse placed near the top lane shows the lane ordering and shows the impulse response spilling into the next block, which separates correct history handling from a per-block convolution. Full-scale constant and alternating blocks push the sum beyond 16 bits in both directions. Signed half-step inputs through a unit tap of 2^-15 tell round-to-nearest apart from truncation and from symmetric rounding. Random streams with idle gaps, staged writes without commit, commits in idle cycles and commits coinciding with a block are each compared, lane by lane, against a serial reference convolution. This shows whether bank swaps land on the right block and whether gaps disturb the history.

// File: rtl/feq_pkg.sv
package feq_pkg;
  localparam int SAMPLE_W = 16;
  localparam int COEF_W   = 16;
  localparam int ACC_W    = 40;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic signed [COEF_W-1:0]   coef_t;
  typedef logic signed [ACC_W-1:0]    acc_t;

  // strobes from control to datapath, one per pipeline stage
  typedef struct packed {
    logic loadBlock;
    logic accEn;
    logic roundEn;
  } strobe_t;

  localparam acc_t SAT_HI = acc_t'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
  localparam acc_t SAT_LO = -SAT_HI - acc_t'(1);

  // round to nearest (ties up), then clamp to the sample range
  function automatic sample_t roundSat(input acc_t value, input int fracBits);
    acc_t biased;
    acc_t shifted;
    biased  = value + (acc_t'(1) <<< (fracBits - 1));
    shifted = biased >>> fracBits;
    if (shifted > SAT_HI) return sample_t'(SAT_HI);
    if (shifted < SAT_LO) return sample_t'(SAT_LO);
    return sample_t'(shifted);
  endfunction
endpackage

// File: rtl/feq_ctrl.sv
module feq_ctrl
  import feq_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              coefWrEn,
  input  logic [ADDR_W-1:0] coefWrAddr,
  input  coef_t             coefWrData,
  input  logic              coefCommit,
  output strobe_t           strobes,
  output coef_t             activeCoefs [TAPS],
  output logic              swapPending
);
  coef_t shadowCoefs [TAPS];
  logic  swapNow;
  logic  accEnQ;
  logic  roundEnQ;

  // a commit outstanding, or one arriving with the block, swaps banks now
  assign swapNow = inValid && (swapPending || coefCommit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TAPS; i++) shadowCoefs[i] <= '0;
    end else if (coefWrEn) begin
      for (int i = 0; i < TAPS; i++)
        if (coefWrAddr == ADDR_W'(i)) shadowCoefs[i] <= coefWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TAPS; i++) activeCoefs[i] <= '0;
    end else if (swapNow) begin
      for (int i = 0; i < TAPS; i++) activeCoefs[i] <= shadowCoefs[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swapPending <= 1'b0;
      accEnQ      <= 1'b0;
      roundEnQ    <= 1'b0;
    end else begin
      if (inValid)         swapPending <= 1'b0;
      else if (coefCommit) swapPending <= 1'b1;
      accEnQ   <= inValid;
      roundEnQ <= accEnQ;
    end
  end

  assign strobes = '{loadBlock: inValid, accEn: accEnQ, roundEn: roundEnQ};
endmodule

// File: rtl/feq_delay.sv
module feq_delay #(
  parameter int WIDTH  = 512,
  parameter int STAGES = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vIn,
  input  logic [WIDTH-1:0] dIn,
  output logic             vOut,
  output logic [WIDTH-1:0] dOut
);
  generate
    if (STAGES == 0) begin : gThrough
      assign vOut = vIn;
      assign dOut = dIn;
    end else begin : gPipe
      logic             vPipe [STAGES];
      logic [WIDTH-1:0] dPipe [STAGES];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int s = 0; s < STAGES; s++) begin
            vPipe[s] <= 1'b0;
            dPipe[s] <= '0;
          end
        end else begin
          vPipe[0] <= vIn;
          if (vIn) dPipe[0] <= dIn;
          for (int s = 1; s < STAGES; s++) begin
            vPipe[s] <= vPipe[s-1];
            if (vPipe[s-1]) dPipe[s] <= dPipe[s-1];
          end
        end
      end

      assign vOut = vPipe[STAGES-1];
      assign dOut = dPipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/feq_datapath.sv
module feq_datapath
  import feq_pkg::*;
#(
  parameter int LANES = 32,
  parameter int TAPS  = 8,
  parameter int FRAC  = 15,
  parameter int EXTRA = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strobes,
  input  logic [LANES*SAMPLE_W-1:0] inData,
  input  coef_t                     activeCoefs [TAPS],
  output logic                      outValid,
  output logic [LANES*SAMPLE_W-1:0] outData
);
  localparam int HIST  = TAPS - 1;
  localparam int WIN   = HIST + LANES;
  localparam int BUS_W = LANES * SAMPLE_W;

  sample_t          blockQ  [LANES];
  sample_t          histQ   [HIST];
  sample_t          win     [WIN];
  acc_t             accNext [LANES];
  acc_t             accQ    [LANES];
  sample_t          roundQ  [LANES];
  logic             roundValidQ;
  logic [BUS_W-1:0] roundFlat;

  // window: history oldest first, then the registered block
  always_comb begin
    for (int j = 0; j < HIST; j++)  win[j] = histQ[j];
    for (int k = 0; k < LANES; k++) win[HIST + k] = blockQ[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < HIST; j++)  histQ[j]  <= '0;
      for (int k = 0; k < LANES; k++) blockQ[k] <= '0;
    end else if (strobes.loadBlock) begin
      for (int j = 0; j < HIST; j++)  histQ[j]  <= win[j + LANES];
      for (int k = 0; k < LANES; k++) blockQ[k] <= inData[k*SAMPLE_W +: SAMPLE_W];
    end
  end

  // one full convolution per lane, tap i reaching i samples back
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      accNext[k] = '0;
      for (int i = 0; i < TAPS; i++)
        accNext[k] = accNext[k] + acc_t'(win[HIST + k - i]) * acc_t'(activeCoefs[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < LANES; k++) accQ[k] <= '0;
    end else if (strobes.accEn) begin
      for (int k = 0; k < LANES; k++) accQ[k] <= accNext[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < LANES; k++) roundQ[k] <= '0;
      roundValidQ <= 1'b0;
    end else begin
      roundValidQ <= strobes.roundEn;
      if (strobes.roundEn)
        for (int k = 0; k < LANES; k++) roundQ[k] <= roundSat(accQ[k], FRAC);
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) roundFlat[k*SAMPLE_W +: SAMPLE_W] = roundQ[k];
  end

  feq_delay #(
    .WIDTH (BUS_W),
    .STAGES(EXTRA)
  ) uDelay (
    .clk (clk),
    .rstN(rstN),
    .vIn (roundValidQ),
    .dIn (roundFlat),
    .vOut(outValid),
    .dOut(outData)
  );
endmodule

// File: rtl/feq_top.sv
module feq_top
  import feq_pkg::*;
#(
  parameter  int LANES  = 32,
  parameter  int TAPS   = 8,
  parameter  int LAT    = 4,
  parameter  int FRAC   = 15,
  localparam int ADDR_W = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int BUS_W  = LANES * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BUS_W-1:0]  inData,
  input  logic              coefWrEn,
  input  logic [ADDR_W-1:0] coefWrAddr,
  input  logic [15:0]       coefWrData,
  input  logic              coefCommit,
  output logic              outValid,
  output logic [BUS_W-1:0]  outData
);
  localparam int EXTRA = LAT - 3;

  strobe_t strobes;
  coef_t   activeCoefs [TAPS];
  logic    swapPending;

  feq_ctrl #(
    .TAPS  (TAPS),
    .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .coefWrEn   (coefWrEn),
    .coefWrAddr (coefWrAddr),
    .coefWrData (coef_t'(coefWrData)),
    .coefCommit (coefCommit),
    .strobes    (strobes),
    .activeCoefs(activeCoefs),
    .swapPending(swapPending)
  );

  feq_datapath #(
    .LANES(LANES),
    .TAPS (TAPS),
    .FRAC (FRAC),
    .EXTRA(EXTRA)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .inData     (inData),
    .activeCoefs(activeCoefs),
    .outValid   (outValid),
    .outData    (outData)
  );
endmodule

// File: rtl/feq_checker.sv
module feq_checker #(
  parameter int LAT   = 4,
  parameter int LANES = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              coefCommit,
  input logic              swapPending,
  input logic              outValid,
  input logic [LANES*16-1:0] outData
);
  logic [LAT-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[LAT-2:0], inValid};
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    outValid == validPipe[LAT-1]); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData)); // R5

  AST_COMMIT_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    coefCommit && !inValid |=> swapPending); // R7

  AST_BLOCK_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> !swapPending); // R7

  AST_NO_SPURIOUS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    !coefCommit && !swapPending |=> !swapPending); // R6
endmodule

bind feq_top feq_checker #(
  .LAT  (LAT),
  .LANES(LANES)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .coefCommit (coefCommit),
  .swapPending(swapPending),
  .outValid   (outValid),
  .outData    (outData)
);

// File: tb/tb_feq_top.sv
`timescale 1ns/1ps
module tb_feq_top;
  localparam int LANES  = 32;
  localparam int TAPS   = 8;
  localparam int LAT    = 4;
  localparam int ADDR_W = 3;
  localparam int BUS_W  = LANES * 16;
  localparam int MAXS   = 4096;
  localparam int QD     = 256;

  // {req[3:0], pattern[3:0], coefSet[3:0], mode[1:0], gap[1:0]}
  // mode 0 keep, 1 stage+idle commit, 2 stage+commit with block, 3 stage only
  localparam logic [15:0] STIM [14] = '{
    {4'd10, 4'd1, 4'd0, 2'd1, 2'd0},  // R10 impulse near top lane
    {4'd1,  4'd0, 4'd0, 2'd0, 2'd0},  // R1 tail into next block
    {4'd9,  4'd2, 4'd0, 2'd0, 2'd2},  // R9 ramp then idle gap
    {4'd9,  4'd3, 4'd0, 2'd0, 2'd0},  // R9 history survives the gap
    {4'd6,  4'd3, 4'd3, 2'd3, 2'd0},  // R6 staged, not committed
    {4'd6,  4'd2, 4'd3, 2'd0, 2'd1},  // R6 still old taps
    {4'd7,  4'd3, 4'd3, 2'd1, 2'd0},  // R7 idle commit
    {4'd4,  4'd4, 4'd1, 2'd2, 2'd0},  // R4 full scale positive, commit with block
    {4'd4,  4'd5, 4'd1, 2'd0, 2'd0},  // R4 full scale negative
    {4'd4,  4'd7, 4'd1, 2'd0, 2'd1},  // R4 alternating extremes
    {4'd3,  4'd6, 4'd2, 2'd1, 2'd0},  // R3 half steps
    {4'd3,  4'd6, 4'd2, 2'd0, 2'd0},  // R3 again
    {4'd7,  4'd3, 4'd4, 2'd2, 2'd3},  // R7 commit with block
    {4'd1,  4'd3, 4'd0, 2'd1, 2'd0}   // R1 decaying taps, random data
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [BUS_W-1:0] inData = '0;
  logic             coefWrEn = 1'b0;
  logic [ADDR_W-1:0] coefWrAddr = '0;
  logic [15:0]      coefWrData = '0;
  logic             coefCommit = 1'b0;
  logic             outValid;
  logic [BUS_W-1:0] outData;

  feq_top #(.LANES(LANES), .TAPS(TAPS), .LAT(LAT), .FRAC(15)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .coefWrEn(coefWrEn), .coefWrAddr(coefWrAddr), .coefWrData(coefWrData),
    .coefCommit(coefCommit), .outValid(outValid), .outData(outData)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    xs [MAXS];
  int    nS = 0;
  int    mActive [TAPS];
  int    mShadow [TAPS];
  bit    mPending = 1'b0;
  int    expData [QD][LANES];
  int    expCyc [QD];
  string expReq [QD];
  int    qHead = 0;
  int    qTail = 0;
  int    lcg = 32'h1234_5678;
  bit    done = 1'b0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nextRand();
    int r;
    lcg = lcg * 1103515245 + 12345;
    r = (lcg >>> 9) & 16'hFFFF;
    if (r >= 32768) r -= 65536;
    return r;
  endfunction

  function automatic int coefFor(int setId, int i);
    int v;
    case (setId)
      0: begin v = 24576; for (int j = 0; j < i; j++) v = -(v / 2); return v; end
      1: return (i < 2) ? 32767 : 0;
      2: return (i == 0) ? 1 : 0;
      3: return nextRand();
      default: return -4096;
    endcase
  endfunction

  function automatic int sampleFor(int pat, int lane);
    case (pat)
      0: return 0;
      1: return (lane == LANES - 3) ? 20000 : 0;
      2: return lane * 1000 - 16000;
      3: return nextRand();
      4: return 32767;
      5: return -32768;
      6: case (lane % 4) 0: return 16384; 1: return -16384; 2: return 16383; default: return -16383; endcase
      default: return (lane % 2 == 1) ? 32767 : -32768;
    endcase
  endfunction

  // serial reference: y[n] = sum h[i] x[n-i], zero before the first sample
  function automatic int refOut(int n);
    longint acc = 0;
    for (int i = 0; i < TAPS; i++)
      if (n - i >= 0) acc += longint'(mActive[i]) * longint'(xs[n-i]);
    acc = (acc + 64'sd16384) >>> 15;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  always @(negedge clk) begin
    if (rstN && outValid && !done) begin
      if (qHead == qTail) begin
        check(1'b0, "R5", "outValid with no block pending", 1, 0);
      end else begin
        check(cyc == expCyc[qHead % QD], "R5", "output cycle", cyc, expCyc[qHead % QD]);
        for (int k = 0; k < LANES; k++) begin
          int got;
          got = int'($signed(outData[k*16 +: 16]));
          check(got == expData[qHead % QD][k], expReq[qHead % QD],
                $sformatf("block %0d lane %0d", qHead, k), got, expData[qHead % QD][k]);
        end
        qHead++;
      end
    end
  end

  task automatic idleCycle();
    @(negedge clk);
    inValid = 1'b0; coefWrEn = 1'b0; coefCommit = 1'b0;
  endtask

  task automatic writeCoef(int a, int v);
    @(negedge clk);
    inValid = 1'b0; coefCommit = 1'b0; coefWrEn = 1'b1;
    coefWrAddr = ADDR_W'(a); coefWrData = 16'(v);
    mShadow[a] = v;
  endtask

  task automatic loadSet(int setId);
    for (int i = 0; i < TAPS; i++) writeCoef(i, coefFor(setId, i));
  endtask

  task automatic commitIdle();
    @(negedge clk);
    inValid = 1'b0; coefWrEn = 1'b0; coefCommit = 1'b1;
    mPending = 1'b1;
  endtask

  task automatic sendBlock(int pat, bit commitNow, string req);
    @(negedge clk);
    coefWrEn = 1'b0; coefCommit = commitNow; inValid = 1'b1;
    if (commitNow || mPending) begin
      for (int i = 0; i < TAPS; i++) mActive[i] = mShadow[i];
      mPending = 1'b0;
    end
    for (int k = 0; k < LANES; k++) begin
      int v;
      v = sampleFor(pat, k);
      inData[k*16 +: 16] = 16'(v);
      xs[nS + k] = v;
    end
    for (int k = 0; k < LANES; k++) expData[qTail % QD][k] = refOut(nS + k);
    expCyc[qTail % QD] = cyc + LAT;
    expReq[qTail % QD] = req;
    qTail++;
    nS += LANES;
  endtask

  task automatic drain(string req);
    repeat (LAT + 3) idleCycle();
    check(qHead == qTail, req, "blocks still owed", qTail - qHead, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0; coefWrEn = 1'b0; coefCommit = 1'b0;
    repeat (2) @(negedge clk);
    check(outValid == 1'b0, "R8", "outValid in reset", outValid, 0);
    check(outData == '0, "R8", "outData in reset nonzero", (outData != '0), 0);
    rstN = 1'b1;
    nS = 0; mPending = 1'b0; qHead = 0; qTail = 0;
    for (int i = 0; i < TAPS; i++) begin mActive[i] = 0; mShadow[i] = 0; end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #800000;
    check(1'b0, "R5", "watchdog expired", 1, 0);
    finishRun();
  end

  initial begin
    for (int i = 0; i < TAPS; i++) begin mActive[i] = 0; mShadow[i] = 0; end
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R8", "outValid at reset", outValid, 0);
    check(outData == '0, "R8", "outData at reset nonzero", (outData != '0), 0);
    rstN = 1'b1;

    for (int e = 0; e < 14; e++) begin
      string req;
      int pat, setId, mode, gap;
      req   = $sformatf("R%0d", STIM[e][15:12]);
      pat   = STIM[e][11:8];
      setId = STIM[e][7:4];
      mode  = STIM[e][3:2];
      gap   = STIM[e][1:0];
      case (mode)
        1: begin loadSet(setId); commitIdle(); sendBlock(pat, 1'b0, req); end
        2: begin loadSet(setId); sendBlock(pat, 1'b1, req); end
        3: begin loadSet(setId); sendBlock(pat, 1'b0, req); end
        default: sendBlock(pat, 1'b0, req);
      endcase
      repeat (gap) idleCycle();
    end

    // random stream with a mid-stream refit (R7) and short gaps (R9)
    for (int b = 0; b < 20; b++) begin
      if (b == 10) loadSet(3);
      sendBlock(3, (b == 12), "R7");
      if ((nextRand() & 3) == 0) idleCycle();
    end
    drain("R5");

    // zero taps after reset give zero outputs
    doReset();
    sendBlock(3, 1'b0, "R8");
    drain("R8");

    // stale history from the random block must not leak past reset
    doReset();
    loadSet(0);
    commitIdle();
    sendBlock(4, 1'b0, "R2");
    drain("R2");

    finishRun();
  end
endmodule